// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block sequences one successive-approximation conversion for each qualified start pulse. It drives a trial word to an external feedback DAC, samples a 1-bit comparator level before every decision, and leaves the result in a parallel register. The coding is negative-true. A bit at 0 is active and a bit at 1 is inactive. The all-ones word stands for the most negative input. A `busy_o` flag is high while a conversion runs, and a gated bit clock marks each step.

Two stepping modes are offered. In internal mode, a divider of the system clock paces the steps. In external mode, every qualified start pulse advances the conversion by one step and the bit clock stays parked. A short-cycle select ends the conversion early, and a mode bit inverts the MSB of the result so that it reads as two's complement.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, `busy_o` is 0, `bclk_o` is 0 and `data_o` is all ones (with `twos_i` = 0).
- R2: A conversion starts on the falling edge of a `start_i` pulse that was high for at least PW_MIN system clocks. A shorter pulse leaves `busy_o` and `data_o` unchanged.
- R3: A start pulse that ends while `busy_o` is high in internal mode neither restarts nor alters the running conversion, and no new conversion follows it.
- R4: In internal mode, `bclk_o` gives exactly k+1 rising edges per conversion, where k is the resolution. Its period is 2*(`div_i`+1) system clocks, and it is 0 whenever `busy_o` is 0.
- R5: Bits are decided MSB first. At the first step, the MSB goes to 0 and all other bits go to 1. Each later step keeps the current trial bit at 0 when the comparator level sampled one clock earlier was 1, otherwise sets it to 1, and sets the next bit to 0. The result is the complement of the input code truncated to k bits.
- R6: In internal mode, `data_o` changes only in the same cycle as a rising edge of `bclk_o`. The result is stable in the cycle in which `busy_o` falls.
- R7: `res_sel_i` picks k as follows: 0→N, 1→N-1, 2→N-2, 3→N-3, 4→N-4, 5→N-6, 6→N-8, 7→N. The select is latched when the conversion starts, and bits below the k-th stay at 1.
- R8: `twos_i` = 1 inverts only bit N-1 (the MSB) of `data_o`.
- R9: In external mode (`ext_mode_i` = 1), each qualified start pulse performs one step and `bclk_o` stays 0. `busy_o` rises after the first pulse, is still high after pulse k, and is low after pulse k+1.
- R10: `busy_o` falls exactly one system clock after the step that holds the last decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Convert-start pulse, acts on its falling edge |
| cmp_i | input | 1 | Comparator level, 1 when the input is at or above the DAC trial |
| res_sel_i | input | 3 | Short-cycle resolution select |
| ext_mode_i | input | 1 | 1: start pulses step the conversion |
| twos_i | input | 1 | 1: invert the result MSB |
| div_i | input | DIV_W | Bit-clock half period minus one, in system clocks |
| trial_o | output | NBITS | Negative-true trial word to the DAC |
| busy_o | output | 1 | Conversion in progress |
| bclk_o | output | 1 | Gated bit clock |
| data_o | output | NBITS | Negative-true result |

## Verification
The hardest state to reach is a start pulse that lands in the middle of a running conversion. To get there, the bench keeps a behavioural comparator closed around `trial_o` and raises a fully qualified pulse several bit-clock periods after `busy_o` rises. It then checks the edge count, the final code and the idle period that follows. The short-cycle codes that truncate deepest are swept the same way. The last-decision edge and the fall of `busy_o` then lie close together, and that spacing is checked per conversion.

// File: rtl/sar_pkg.sv
package sar_pkg;
  function automatic int unsigned res_of(input logic [2:0] sel, input int unsigned nb);
    int unsigned off;
    case (sel)
      3'd1:    off = 1;
      3'd2:    off = 2;
      3'd3:    off = 3;
      3'd4:    off = 4;
      3'd5:    off = 6;
      3'd6:    off = 8;
      default: off = 0;
    endcase
    return (off >= nb) ? 1 : nb - off;
  endfunction
endpackage

// File: rtl/sar_start_filter.sv
module sar_start_filter #(
  parameter int unsigned PW_MIN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic evt_o
);
  localparam int unsigned CW = $clog2(PW_MIN + 1);

  logic          s1_q, s2_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      s1_q <= start_i;
      s2_q <= s1_q;
      if (s1_q) cnt_q <= (cnt_q == CW'(PW_MIN)) ? cnt_q : cnt_q + 1'b1;
      else      cnt_q <= '0;
    end
  end

  // trailing edge of a pulse long enough
  assign evt_o = s2_q & ~s1_q & (cnt_q == CW'(PW_MIN));
endmodule

// File: rtl/sar_bit_clock.sv
module sar_bit_clock #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             bclk_o,
  output logic             rise_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             bclk_q;
  logic             wrap;

  assign wrap = (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      bclk_q <= ~bclk_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign bclk_o = bclk_q;
  assign rise_o = run_i & wrap & ~bclk_q;

  AST_BCLK_PARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(run_i) |-> !bclk_q) else $error("bclk not parked"); // R4
endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
  parameter int unsigned NBITS = 16,
  parameter int unsigned CW    = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [CW-1:0]    idx_i,
  input  logic [CW-1:0]    res_i,
  input  logic             cmp_i,
  input  logic             busy_i,
  output logic [NBITS-1:0] sar_o
);
  logic [NBITS-1:0] sar_q, nxt;

  always_comb begin
    nxt = sar_q;
    if (idx_i == '0) begin
      nxt = '1;
      nxt[NBITS-1] = 1'b0;
    end else begin
      for (int i = 0; i < NBITS; i++) begin
        if (CW'(NBITS - i) == idx_i) nxt[i] = ~cmp_i;
        if ((CW'(NBITS - 1 - i) == idx_i) && (idx_i < res_i)) nxt[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sar_q <= '1;
    else if (step_i) sar_q <= nxt;
  end

  assign sar_o = sar_q;

  logic [NBITS-1:0] lo_mask;
  always_comb begin
    for (int i = 0; i < NBITS; i++) lo_mask[i] = (i < (NBITS - int'(res_i)));
  end

  AST_DATA_ON_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sar_q != $past(sar_q)) |-> $past(step_i)) else $error("data moved off step"); // R6
  AST_LOW_BITS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && idx_i != '0) |-> ((sar_q & lo_mask) == lo_mask)) else $error("low bit active"); // R7
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_pkg::*;
#(
  parameter int unsigned NBITS  = 16,
  parameter int unsigned PW_MIN = 3,
  parameter int unsigned DIV_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cmp_i,
  input  logic [2:0]       res_sel_i,
  input  logic             ext_mode_i,
  input  logic             twos_i,
  input  logic [DIV_W-1:0] div_i,
  output logic [NBITS-1:0] trial_o,
  output logic             busy_o,
  output logic             bclk_o,
  output logic [NBITS-1:0] data_o
);
  localparam int unsigned CW = $clog2(NBITS + 1);

  logic          start_evt, bclk_rise, bclk;
  logic          busy_q, ext_q, done_q, cmp_q;
  logic [CW-1:0] step_q, res_q, res_now;
  logic          go, step_evt, last;
  logic [NBITS-1:0] sar;

  sar_start_filter #(.PW_MIN(PW_MIN)) u_filt (
    .clk_i, .rst_ni, .start_i, .evt_o(start_evt)
  );

  sar_bit_clock #(.DIV_W(DIV_W)) u_bclk (
    .clk_i, .rst_ni,
    .run_i (busy_q & ~ext_q & ~done_q),
    .div_i,
    .bclk_o(bclk),
    .rise_o(bclk_rise)
  );

  // comparator sampled one clock ahead of every decision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmp_q <= 1'b0;
    else         cmp_q <= cmp_i;
  end

  assign res_now  = busy_q ? res_q : CW'(res_of(res_sel_i, NBITS));
  assign go       = start_evt & ~busy_q;
  assign step_evt = ~done_q & ((busy_q & ~ext_q & bclk_rise) |
                               (busy_q &  ext_q & start_evt) |
                               (go & ext_mode_i));
  assign last     = step_evt & (step_q == res_now);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ext_q  <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
      res_q  <= CW'(NBITS);
    end else if (done_q) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
    end else begin
      if (go) begin
        busy_q <= 1'b1;
        ext_q  <= ext_mode_i;
        res_q  <= res_now;
      end
      if (step_evt) begin
        if (last) done_q <= 1'b1;
        else      step_q <= step_q + 1'b1;
      end
    end
  end

  sar_approx_reg #(.NBITS(NBITS), .CW(CW)) u_sar (
    .clk_i, .rst_ni,
    .step_i(step_evt),
    .idx_i (step_q),
    .res_i (res_now),
    .cmp_i (cmp_q),
    .busy_i(busy_q),
    .sar_o (sar)
  );

  assign trial_o = sar;
  assign busy_o  = busy_q;
  assign bclk_o  = bclk;
  assign data_o  = {sar[NBITS-1] ^ twos_i, sar[NBITS-2:0]};

  AST_BCLK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !bclk_o) else $error("bclk high while idle"); // R4
  AST_EXT_NO_BCLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && ext_q) |-> !bclk_o) else $error("bclk in external mode"); // R9
  AST_BUSY_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_evt)) else $error("busy without start"); // R2
  AST_DATA_SETTLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $stable(trial_o)) else $error("data moved at busy fall"); // R6
  AST_RES_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(res_q)) else $error("resolution changed"); // R7
endmodule

// File: tb/sar_conv_ctrl_tb_top.sv
module sar_conv_ctrl_tb_top;
  localparam int NB = 10;
  localparam int PW = 3;
  localparam int DW = 4;

  logic clk = 0, rst_n = 0;
  logic start = 0, ext = 0, twos = 0;
  logic [2:0] sel = 0;
  logic [DW-1:0] div = 0;
  logic [NB-1:0] vin = 0;
  logic [NB-1:0] trial, data, tt;
  logic busy, bclk, cmp;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  assign tt  = ~trial;
  assign cmp = (vin >= tt);

  sar_conv_ctrl #(.NBITS(NB), .PW_MIN(PW), .DIV_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmp_i(cmp),
    .res_sel_i(sel), .ext_mode_i(ext), .twos_i(twos), .div_i(div),
    .trial_o(trial), .busy_o(busy), .bclk_o(bclk), .data_o(data));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int res_tb(input int s);
    case (s)
      1: return NB - 1;  2: return NB - 2;  3: return NB - 3;
      4: return NB - 4;  5: return NB - 6;  6: return NB - 8;
      default: return NB;
    endcase
  endfunction

  function automatic logic [NB-1:0] exp_code(input logic [NB-1:0] v, input int k, input bit tw);
    logic [NB-1:0] m, e;
    m = ~((NB'(1) << (NB - k)) - NB'(1));
    e = ~(v & m);
    if (tw) e[NB-1] = ~e[NB-1];
    return e;
  endfunction

  task automatic pulse(input int h);
    start = 1;
    repeat (h) @(negedge clk);
    start = 0;
  endtask

  // internal-mode conversion; inj > 0 raises a stray start pulse inj cycles into busy
  task automatic conv_int(input logic [NB-1:0] v, input int s, input int d, input bit tw, input int inj);
    int k, rises, cyc, last_rise, wait_c;
    logic pb, pbusy;
    logic [NB-1:0] pd;
    bit per_ok, chg_ok;
    k = res_tb(s);
    vin = v; sel = 3'(s); div = DW'(d); twos = tw; ext = 0;
    pulse(PW);
    wait_c = 0;
    while (!busy && wait_c < 8) begin @(negedge clk); wait_c++; end
    chk(busy, "R2 busy after start", int'(busy), 1);
    sel = 3'(s ^ 1); // R7 select is latched
    rises = 0; cyc = 0; last_rise = -1; per_ok = 1; chg_ok = 1;
    pb = bclk; pd = data; pbusy = busy;
    while (busy && cyc < 4000) begin
      @(negedge clk); cyc++;
      if (inj > 0 && cyc == inj) start = 1;
      if (inj > 0 && cyc == inj + PW) start = 0;
      if (bclk && !pb) begin
        if (last_rise >= 0 && cyc - last_rise != 2 * (d + 1)) per_ok = 0;
        last_rise = cyc; rises++;
      end
      if (data != pd && !(bclk && !pb)) chg_ok = 0;
      if (!busy && data != pd) chg_ok = 0;
      pb = bclk; pd = data;
    end
    chk(rises == k + 1, "R4 bit clock edge count", rises, k + 1);
    chk(per_ok, "R4 bit clock period", int'(per_ok), 1);
    chk(chg_ok, "R6 data changes only on bit clock rise", int'(chg_ok), 1);
    chk(!bclk, "R4 bit clock low after end", int'(bclk), 0);
    chk(data == exp_code(v, k, tw), tw ? "R8 twos result" : (s != 0 ? "R7 short cycle result" : "R5 result"),
        int'(data), int'(exp_code(v, k, tw)));
    if (inj > 0) begin
      cyc = 0;
      repeat (20) begin @(negedge clk); if (busy) cyc++; end
      chk(cyc == 0, "R3 stray start ignored", cyc, 0);
    end
    sel = 0;
    @(negedge clk);
  endtask

  task automatic conv_ext(input logic [NB-1:0] v, input int s);
    int k;
    bit bc_ok;
    k = res_tb(s);
    vin = v; sel = 3'(s); twos = 0; ext = 1; bc_ok = 1;
    for (int p = 0; p <= k; p++) begin
      pulse(PW);
      repeat (6) begin @(negedge clk); if (bclk) bc_ok = 0; end
      if (p == 0)     chk(busy, "R9 busy after first pulse", int'(busy), 1);
      if (p == k - 1) chk(busy, "R9 busy after pulse k", int'(busy), 1);
      if (p == k)     chk(!busy, "R9 idle after pulse k+1", int'(busy), 0);
    end
    chk(bc_ok, "R9 bit clock parked", int'(bc_ok), 1);
    chk(data == exp_code(v, k, 0), "R9 external result", int'(data), int'(exp_code(v, k, 0)));
    ext = 0;
  endtask

  // R10: busy falls one clock after the final decision edge
  task automatic chk_fall_gap();
    int gap;
    logic pb;
    vin = NB'(321); sel = 0; div = 0; twos = 0; ext = 0;
    pulse(PW);
    while (!busy) @(negedge clk);
    gap = -1; pb = bclk;
    while (busy) begin
      @(negedge clk);
      if (bclk && !pb) gap = 0; else if (gap >= 0) gap++;
      pb = bclk;
    end
    chk(gap == 1, "R10 busy fall delay", gap, 1);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy, "R1 reset busy", int'(busy), 0);
    chk(!bclk, "R1 reset bclk", int'(bclk), 0);
    chk(data == '1, "R1 reset data", int'(data), int'({NB{1'b1}}));
    // R2 short pulse rejected
    pulse(PW - 1);
    repeat (8) @(negedge clk);
    chk(!busy, "R2 short pulse ignored busy", int'(busy), 0);
    chk(data == '1, "R2 short pulse ignored data", int'(data), int'({NB{1'b1}}));
    for (int v = 0; v < (1 << NB); v++) conv_int(NB'(v), 0, 0, 0, 0);
    for (int s = 0; s < 8; s++)
      for (int v = 0; v < (1 << NB); v += 37) conv_int(NB'(v), s, 0, 0, 0);
    for (int v = 0; v < (1 << NB); v += 61) conv_int(NB'(v), 0, 0, 1, 0);
    conv_int(NB'(0), 2, 0, 1, 0);
    conv_int(NB'(1023), 0, 2, 0, 0);
    conv_int(NB'(512), 0, 5, 0, 0);
    conv_int(NB'(700), 0, 1, 0, 9);
    conv_int(NB'(77), 6, 2, 0, 15);
    chk_fall_gap();
    for (int v = 0; v < (1 << NB); v += 149) conv_ext(NB'(v), 0);
    conv_ext(NB'(1023), 6);
    conv_ext(NB'(300), 5);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule